// File: doc/BRIEF.md
# Flash Program/Erase Status Poller

This block sits on the host side of a byte-wide parallel flash bus. A single request names an operation (byte program, whole-array erase or sector erase), a target address, a data byte and, for sector erase, a bitmap of the sectors to erase. The engine issues the unlock and command write cycles for that operation. It then reads the device status byte repeatedly and decides the outcome from the status bits. It does not wait on a ready pin.

The completion test compares a toggle bit (bit 6) across two consecutive status reads. If bit 6 keeps changing while the overrun flag (bit 5) is set, the engine takes one more read pair to confirm before it declares a failure. For a multi-sector erase, the engine adds each further sector with another 30h write. It samples the erase-window flag (bit 3) before and after each of these writes. Any failure ends with the reset command (F0h) so the device returns to array reads. A programmable limit on polling rounds guards against a device that never settles.

The bus uses a simple request/acknowledge handshake. One bus cycle completes on every clock edge where `fb_req` and `fb_ack` are both high. Only one operation is outstanding at a time.

Top module: `flash_poll_engine`

## Requirements
- R1: A program request (op = 0) issues exactly these writes: AAh at 555h, 55h at 2AAh, A0h at 555h, then the data byte at the target address. Status reads are then made at the target address.
- R2: A whole-array erase (op = 1) issues AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, 10h@555h. Status reads are then made at address 0.
- R3: A sector erase (op = 2) issues the same first five writes as R2, then 30h at the base of the lowest sector set in `sect_mask`. The sector base is the sector index in address bits [AW-1:SECT_BITS]. Each further set sector, in ascending order, gets one status read, then 30h at its base, then one status read. All status reads use the first sector's base.
- R4: Polling reads the status byte twice in a row. If bit 6 is equal in both reads, the operation is complete and succeeds (`fail` = 0, `fail_code` = 0).
- R5: If bit 6 differs and bit 5 of the second read is 0, the engine starts a new read pair.
- R6: If bit 6 differs and bit 5 of the second read is 1, the engine makes two more reads. Equal bit 6 means success. A differing bit 6 means `fail_code` = 1, preceded by a write of F0h at address 0.
- R7: During R3, if bit 3 reads 1 before or after an added 30h write, no further sectors are added. Polling continues. When polling finds the device settled, the result is `fail_code` = 3, preceded by F0h at address 0.
- R8: If `max_polls` read pairs in a row end as in R5, the engine writes F0h at address 0 and reports `fail_code` = 2. A `max_polls` of 0 behaves like 1.
- R9: `busy` is high from the cycle after an accepted start until the result. `start` is ignored while `busy` is high, and also when op = 3.
- R10: While `fb_req` is high and `fb_ack` is low, `fb_wr`, `fb_addr` and `fb_wdata` hold their values.
- R11: `done` is a one-cycle pulse with `busy` low. `fail` and `fail_code` hold the result until the next result. After reset, `busy`, `done`, `fb_req`, `fail` and `fail_code` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request a new operation (sampled when idle) |
| op | input | 2 | 0 program, 1 whole-array erase, 2 sector erase, 3 no-op |
| tgt_addr | input | AW | Program target address |
| tgt_data | input | DW | Program data byte |
| sect_mask | input | NSEC | Sectors to erase for op 2 |
| max_polls | input | PW | Maximum unsettled read pairs |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle result strobe |
| fail | output | 1 | Result is a failure |
| fail_code | output | 2 | 0 ok, 1 overrun confirmed, 2 poll limit, 3 sector refused |
| fb_req | output | 1 | Bus cycle requested |
| fb_wr | output | 1 | 1 write, 0 read |
| fb_addr | output | AW | Bus address |
| fb_wdata | output | DW | Write data (0 on reads) |
| fb_ack | input | 1 | Bus cycle completes this edge when high with `fb_req` |
| fb_rdata | input | DW | Read data, valid on the completing edge |

## Verification
The bound checker watches several properties on every cycle. It checks that request fields stay stable during acknowledge stalls, that `done` is a single-cycle pulse outside `busy`, and that the idle engine stays idle unless a valid start arrives. It also checks that every accepted start opens with the first unlock write and that success and failure codes agree with `fail`. The exact command byte order, the choice between pair restart, confirmation and the reset write, and the bit-3 refusal path depend on scripted status sequences from the device. Only the bench's scenarios, which compare every bus cycle against a queue of expected transactions, can show those.

// File: rtl/fps_pkg.sv
// Shared definitions for the flash status poller.
// Assumes a byte-wide command set with 11-bit unlock addresses.
package fps_pkg;

    typedef enum logic [1:0] {
        OP_PROG = 2'd0,
        OP_CHIP = 2'd1,
        OP_SECT = 2'd2,
        OP_NONE = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        FC_NONE    = 2'd0,
        FC_TIMEOUT = 2'd1,
        FC_LIMIT   = 2'd2,
        FC_REJECT  = 2'd3
    } fcode_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CMD,
        S_ADD_PRE,
        S_ADD_WR,
        S_ADD_POST,
        S_POLL_A,
        S_POLL_B,
        S_CONF_A,
        S_CONF_B,
        S_RESET_WR
    } st_e;

    localparam logic [10:0] UNLK_ADDR_A = 11'h555;
    localparam logic [10:0] UNLK_ADDR_B = 11'h2AA;

    localparam logic [7:0] CMD_UNLK_A  = 8'hAA;
    localparam logic [7:0] CMD_UNLK_B  = 8'h55;
    localparam logic [7:0] CMD_PROG    = 8'hA0;
    localparam logic [7:0] CMD_ESETUP  = 8'h80;
    localparam logic [7:0] CMD_CHIP    = 8'h10;
    localparam logic [7:0] CMD_SECT    = 8'h30;
    localparam logic [7:0] CMD_RESET   = 8'hF0;

endpackage

// File: rtl/fps_cmd_seq.sv
// Command sequence table: maps an operation and step number to the
// address and data of that write cycle, and flags the final step.
// Assumes steps are presented in order starting at 0.
module fps_cmd_seq
    import fps_pkg::*;
#(
    parameter int AW = 19,
    parameter int DW = 8
) (
    input  logic [1:0]    op,
    input  logic [2:0]    step,
    input  logic [AW-1:0] tgt_addr,
    input  logic [DW-1:0] tgt_data,
    input  logic [AW-1:0] sect_base,
    output logic [AW-1:0] cyc_addr,
    output logic [DW-1:0] cyc_data,
    output logic          last
);

    localparam logic [AW-1:0] ADDR_A = AW'(UNLK_ADDR_A);
    localparam logic [AW-1:0] ADDR_B = AW'(UNLK_ADDR_B);

    // Select the write cycle for the current step
    always_comb begin
        cyc_addr = ADDR_A;
        cyc_data = DW'(CMD_UNLK_A);
        last     = 1'b0;
        case (step)
            3'd0: begin
                cyc_addr = ADDR_A;
                cyc_data = DW'(CMD_UNLK_A);
            end
            3'd1, 3'd4: begin
                cyc_addr = ADDR_B;
                cyc_data = DW'(CMD_UNLK_B);
            end
            3'd2: begin
                cyc_addr = ADDR_A;
                cyc_data = (op == OP_PROG) ? DW'(CMD_PROG) : DW'(CMD_ESETUP);
            end
            3'd3: begin
                if (op == OP_PROG) begin
                    cyc_addr = tgt_addr;
                    cyc_data = tgt_data;
                    last     = 1'b1;
                end else begin
                    cyc_addr = ADDR_A;
                    cyc_data = DW'(CMD_UNLK_A);
                end
            end
            default: begin
                last = 1'b1;
                if (op == OP_SECT) begin
                    cyc_addr = sect_base;
                    cyc_data = DW'(CMD_SECT);
                end else begin
                    cyc_addr = ADDR_A;
                    cyc_data = DW'(CMD_CHIP);
                end
            end
        endcase
    end

endmodule

// File: rtl/fps_sector_pick.sv
// Finds the lowest set bit of a sector bitmap.
// Assumes an all-zero mask yields index 0 with any = 0.
module fps_sector_pick #(
    parameter int NSEC = 8,
    parameter int SW   = 3
) (
    input  logic [NSEC-1:0] mask,
    output logic [SW-1:0]   idx,
    output logic            any
);

    // Scan from the top so the lowest set bit is the last one written
    always_comb begin
        idx = '0;
        any = |mask;
        for (int i = NSEC - 1; i >= 0; i--) begin
            if (mask[i]) idx = SW'(i);
        end
    end

endmodule

// File: rtl/fps_status_judge.sv
// Decodes a pair of status reads: whether the toggle bit settled, and
// the overrun and erase-window flags of the newer read.
// Assumes bit positions are fixed per device family.
module fps_status_judge #(
    parameter int DW      = 8,
    parameter int TOG_BIT = 6,
    parameter int OVR_BIT = 5,
    parameter int WIN_BIT = 3
) (
    input  logic [DW-1:0] older,
    input  logic [DW-1:0] newer,
    output logic          settled,
    output logic          overrun,
    output logic          win_shut
);

    // Pure decode of the two status bytes
    always_comb begin
        settled  = (older[TOG_BIT] == newer[TOG_BIT]);
        overrun  = newer[OVR_BIT];
        win_shut = newer[WIN_BIT];
    end

endmodule

// File: rtl/fps_poll_limit.sv
// Counts unsettled polling rounds and flags the round that reaches the
// programmed limit. Assumes a limit of 0 acts like 1.
module fps_poll_limit #(
    parameter int PW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    input  logic [PW-1:0] max_polls,
    output logic          last_round
);

    logic [PW-1:0] cnt;

    // Round counter, cleared per operation
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else if (inc) cnt <= cnt + PW'(1);
    end

    // The round being counted now is the final one allowed
    assign last_round = ({1'b0, cnt} + (PW+1)'(1)) >= {1'b0, max_polls};

endmodule

// File: rtl/flash_poll_engine.sv
// Host-side flash program/erase engine. Issues the command write
// sequence, then polls status and decides success or failure from the
// toggle, overrun and erase-window bits; writes the reset command on
// any failure. Assumes one outstanding operation and a bus cycle that
// completes on each edge where fb_req and fb_ack are both high.
module flash_poll_engine
    import fps_pkg::*;
#(
    parameter int AW        = 19,
    parameter int DW        = 8,
    parameter int SECT_BITS = 16,
    parameter int PW        = 16,
    localparam int SW       = AW - SECT_BITS,
    localparam int NSEC     = 1 << SW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [1:0]      op,
    input  logic [AW-1:0]   tgt_addr,
    input  logic [DW-1:0]   tgt_data,
    input  logic [NSEC-1:0] sect_mask,
    input  logic [PW-1:0]   max_polls,
    output logic            busy,
    output logic            done,
    output logic            fail,
    output logic [1:0]      fail_code,
    output logic            fb_req,
    output logic            fb_wr,
    output logic [AW-1:0]   fb_addr,
    output logic [DW-1:0]   fb_wdata,
    input  logic            fb_ack,
    input  logic [DW-1:0]   fb_rdata
);

    st_e             state;
    logic [1:0]      op_q;
    logic [AW-1:0]   addr_q;
    logic [DW-1:0]   data_q;
    logic [AW-1:0]   rd_addr_q;
    logic [NSEC-1:0] mask_q;
    logic [SW-1:0]   cur_sect;
    logic [2:0]      step_q;
    logic [DW-1:0]   first_q;
    logic            rej_q;
    logic            done_q;
    logic            fail_q;
    logic [1:0]      fcode_q;
    logic [1:0]      pend_code;

    logic [AW-1:0]   seq_addr;
    logic [DW-1:0]   seq_data;
    logic            seq_last;
    logic [AW-1:0]   sect_base;
    logic [SW-1:0]   in_idx;
    logic            in_any;
    logic [SW-1:0]   nxt_idx;
    logic            nxt_any;
    logic            settled;
    logic            overrun;
    logic            win_shut;
    logic            last_round;
    logic            go;
    logic            accept;
    logic            lim_clr;
    logic            lim_inc;

    assign sect_base = {cur_sect, {SECT_BITS{1'b0}}};
    assign go        = fb_req && fb_ack;
    assign accept    = (state == S_IDLE) && start && (op != OP_NONE);

    fps_cmd_seq #(.AW(AW), .DW(DW)) u_seq (
        .op        (op_q),
        .step      (step_q),
        .tgt_addr  (addr_q),
        .tgt_data  (data_q),
        .sect_base (sect_base),
        .cyc_addr  (seq_addr),
        .cyc_data  (seq_data),
        .last      (seq_last)
    );

    fps_sector_pick #(.NSEC(NSEC), .SW(SW)) u_pick_in (
        .mask (sect_mask),
        .idx  (in_idx),
        .any  (in_any)
    );

    fps_sector_pick #(.NSEC(NSEC), .SW(SW)) u_pick_rem (
        .mask (mask_q),
        .idx  (nxt_idx),
        .any  (nxt_any)
    );

    fps_status_judge #(.DW(DW)) u_judge (
        .older    (first_q),
        .newer    (fb_rdata),
        .settled  (settled),
        .overrun  (overrun),
        .win_shut (win_shut)
    );

    assign lim_clr = accept;
    assign lim_inc = (state == S_POLL_B) && go && !settled && !overrun;

    fps_poll_limit #(.PW(PW)) u_limit (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (lim_clr),
        .inc        (lim_inc),
        .max_polls  (max_polls),
        .last_round (last_round)
    );

    // Drive the bus cycle selected by the current state
    always_comb begin
        fb_req   = (state != S_IDLE);
        fb_wr    = 1'b0;
        fb_addr  = rd_addr_q;
        fb_wdata = '0;
        case (state)
            S_CMD: begin
                fb_wr    = 1'b1;
                fb_addr  = seq_addr;
                fb_wdata = seq_data;
            end
            S_ADD_WR: begin
                fb_wr    = 1'b1;
                fb_addr  = sect_base;
                fb_wdata = DW'(CMD_SECT);
            end
            S_RESET_WR: begin
                fb_wr    = 1'b1;
                fb_addr  = '0;
                fb_wdata = DW'(CMD_RESET);
            end
            default: ;
        endcase
    end

    // Operation sequencer and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            op_q      <= OP_PROG;
            addr_q    <= '0;
            data_q    <= '0;
            rd_addr_q <= '0;
            mask_q    <= '0;
            cur_sect  <= '0;
            step_q    <= '0;
            first_q   <= '0;
            rej_q     <= 1'b0;
            done_q    <= 1'b0;
            fail_q    <= 1'b0;
            fcode_q   <= FC_NONE;
            pend_code <= FC_NONE;
        end else begin
            done_q <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (accept) begin
                        state    <= S_CMD;
                        op_q     <= op;
                        addr_q   <= tgt_addr;
                        data_q   <= tgt_data;
                        step_q   <= '0;
                        rej_q    <= 1'b0;
                        cur_sect <= in_idx;
                        if (op == OP_SECT) begin
                            mask_q    <= sect_mask & ~(NSEC'(in_any) << in_idx);
                            rd_addr_q <= {in_idx, {SECT_BITS{1'b0}}};
                        end else begin
                            mask_q    <= '0;
                            rd_addr_q <= (op == OP_PROG) ? tgt_addr : '0;
                        end
                    end
                end
                S_CMD: if (go) begin
                    step_q <= step_q + 3'd1;
                    if (seq_last) state <= (mask_q != '0) ? S_ADD_PRE : S_POLL_A;
                end
                S_ADD_PRE: if (go) begin
                    if (win_shut) begin
                        rej_q <= 1'b1;
                        state <= S_POLL_A;
                    end else begin
                        cur_sect <= nxt_idx;
                        state    <= S_ADD_WR;
                    end
                end
                S_ADD_WR: if (go) begin
                    mask_q[cur_sect] <= 1'b0;
                    state            <= S_ADD_POST;
                end
                S_ADD_POST: if (go) begin
                    if (win_shut) begin
                        rej_q <= 1'b1;
                        state <= S_POLL_A;
                    end else begin
                        state <= nxt_any ? S_ADD_PRE : S_POLL_A;
                    end
                end
                S_POLL_A, S_CONF_A: if (go) begin
                    first_q <= fb_rdata;
                    state   <= (state == S_POLL_A) ? S_POLL_B : S_CONF_B;
                end
                S_POLL_B, S_CONF_B: if (go) begin
                    if (settled) begin
                        if (rej_q) begin
                            pend_code <= FC_REJECT;
                            state     <= S_RESET_WR;
                        end else begin
                            state   <= S_IDLE;
                            done_q  <= 1'b1;
                            fail_q  <= 1'b0;
                            fcode_q <= FC_NONE;
                        end
                    end else if (state == S_CONF_B) begin
                        pend_code <= FC_TIMEOUT;
                        state     <= S_RESET_WR;
                    end else if (overrun) begin
                        state <= S_CONF_A;
                    end else if (last_round) begin
                        pend_code <= FC_LIMIT;
                        state     <= S_RESET_WR;
                    end else begin
                        state <= S_POLL_A;
                    end
                end
                S_RESET_WR: if (go) begin
                    state   <= S_IDLE;
                    done_q  <= 1'b1;
                    fail_q  <= 1'b1;
                    fcode_q <= pend_code;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assign busy      = (state != S_IDLE);
    assign done      = done_q;
    assign fail      = fail_q;
    assign fail_code = fcode_q;

endmodule

// File: rtl/fps_checker.sv
// Cycle-level properties of the flash poller's ports, bound to the top.
// Assumes the default command byte values of fps_pkg.
module fps_checker #(
    parameter int AW = 19,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [1:0]    op,
    input logic          busy,
    input logic          done,
    input logic          fail,
    input logic [1:0]    fail_code,
    input logic          fb_req,
    input logic          fb_wr,
    input logic [AW-1:0] fb_addr,
    input logic [DW-1:0] fb_wdata,
    input logic          fb_ack
);

    // R10
    bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fb_req && !fb_ack) |=> (fb_req && $stable(fb_wr) && $stable(fb_addr) && $stable(fb_wdata)));

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R9
    start_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && op != 2'd3) |=> busy);

    // R9
    stay_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !(start && op != 2'd3)) |=> !busy);

    // R1
    first_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && op != 2'd3) |=> (fb_req && fb_wr && fb_wdata == DW'(8'hAA) && fb_addr == AW'(11'h555)));

    // R6
    fail_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fail) |-> (fail_code != 2'd0));

    // R4
    ok_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fail) |-> (fail_code == 2'd0));

endmodule

bind flash_poll_engine fps_checker #(.AW(AW), .DW(DW)) u_fps_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .op        (op),
    .busy      (busy),
    .done      (done),
    .fail      (fail),
    .fail_code (fail_code),
    .fb_req    (fb_req),
    .fb_wr     (fb_wr),
    .fb_addr   (fb_addr),
    .fb_wdata  (fb_wdata),
    .fb_ack    (fb_ack)
);

// File: tb/test_flash_poll_engine.sv
// Scoreboard bench: tasks queue expected bus cycles, status replies and
// results; a negedge monitor answers reads and compares every cycle.
module test_flash_poll_engine;

    localparam int AW   = 19;
    localparam int DW   = 8;
    localparam int SB   = 16;
    localparam int PW   = 16;
    localparam int NSEC = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [1:0]      op = 2'd0;
    logic [AW-1:0]   tgt_addr = '0;
    logic [DW-1:0]   tgt_data = '0;
    logic [NSEC-1:0] sect_mask = '0;
    logic [PW-1:0]   max_polls = 16'd100;
    logic            busy, done, fail;
    logic [1:0]      fail_code;
    logic            fb_req, fb_wr;
    logic [AW-1:0]   fb_addr;
    logic [DW-1:0]   fb_wdata;
    logic            fb_ack = 1'b1;
    logic [DW-1:0]   fb_rdata = 8'hFF;

    always #5 clk = ~clk;

    flash_poll_engine #(.AW(AW), .DW(DW), .SECT_BITS(SB), .PW(PW)) i_flash_poll_engine (
        .clk, .rst_n, .start, .op, .tgt_addr, .tgt_data, .sect_mask, .max_polls,
        .busy, .done, .fail, .fail_code,
        .fb_req, .fb_wr, .fb_addr, .fb_wdata, .fb_ack, .fb_rdata
    );

    typedef struct packed {
        logic          wr;
        logic [AW-1:0] a;
        logic [DW-1:0] d;
    } txn_t;

    txn_t        exp_q[$];
    string       tag_q[$];
    logic [7:0]  stat_q[$];
    logic [2:0]  res_q[$];
    string       rtag_q[$];
    int          checks = 0;
    int          errors = 0;
    int          dones = 0;
    bit          stall = 1'b0;
    bit          rd_inflight = 1'b0;

    localparam logic [AW-1:0] UA = 19'h00555;
    localparam logic [AW-1:0] UB = 19'h002AA;

    task automatic ew(input logic [AW-1:0] a, input logic [7:0] d, input string t);
        exp_q.push_back({1'b1, a, d});
        tag_q.push_back(t);
    endtask

    task automatic er(input logic [AW-1:0] a, input logic [7:0] s, input string t);
        exp_q.push_back({1'b0, a, 8'h00});
        tag_q.push_back(t);
        stat_q.push_back(s);
    endtask

    task automatic eres(input logic f, input logic [1:0] c, input string t);
        res_q.push_back({f, c});
        rtag_q.push_back(t);
    endtask

    task automatic chk(input bit ok, input string t, input string what, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", t, what, act, expv);
        end
    endtask

    task automatic erase_head(input string t);
        ew(UA, 8'hAA, t); ew(UB, 8'h55, t); ew(UA, 8'h80, t);
        ew(UA, 8'hAA, t); ew(UB, 8'h55, t);
    endtask

    task automatic kick(input logic [1:0] o, input logic [AW-1:0] a, input logic [7:0] d,
                        input logic [NSEC-1:0] m, input logic [PW-1:0] mp);
        @(negedge clk);
        op = o; tgt_addr = a; tgt_data = d; sect_mask = m; max_polls = mp;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic finish_op(input string t);
        int n0;
        bit seen;
        n0 = dones;
        seen = 1'b0;
        for (int i = 0; i < 3000 && !seen; i++) begin
            @(negedge clk);
            if (dones > n0) seen = 1'b1;
        end
        chk(seen, t, "watchdog: result strobe", int'(seen), 1);
        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, t, "bus cycles left unissued", exp_q.size(), 0);
        chk(res_q.size() == 0, t, "results left unreported", res_q.size(), 0);
        chk(busy == 1'b0, t, "busy after result", int'(busy), 0);
        if (!seen || exp_q.size() != 0) begin
            exp_q.delete(); tag_q.delete(); stat_q.delete(); res_q.delete(); rtag_q.delete();
            rst_n = 1'b0;
            repeat (3) @(negedge clk);
            rst_n = 1'b1;
        end
    endtask

    // Monitor: answer reads, pace acknowledges, score bus cycles and results
    initial begin
        forever begin
            @(negedge clk);
            if (rd_inflight) begin
                if (stat_q.size() > 0) void'(stat_q.pop_front());
                rd_inflight = 1'b0;
            end
            fb_rdata = (stat_q.size() > 0) ? stat_q[0] : 8'hFF;
            fb_ack   = stall ? ~fb_ack : 1'b1;
            if (rst_n && fb_req && fb_ack) begin
                txn_t got;
                got = {fb_wr, fb_addr, (fb_wr ? fb_wdata : 8'h00)};
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R9", "unexpected bus cycle", int'(got), 0);
                end else begin
                    txn_t e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk(got == e, t, "bus cycle {wr,addr,data}", int'(got), int'(e));
                end
                if (!fb_wr) rd_inflight = 1'b1;
            end
            if (rst_n && done) begin
                dones++;
                if (res_q.size() == 0) begin
                    chk(1'b0, "R9", "unexpected result", int'({fail, fail_code}), 0);
                end else begin
                    logic [2:0] r;
                    string t;
                    r = res_q.pop_front();
                    t = rtag_q.pop_front();
                    chk({fail, fail_code} == r, t, "result {fail,code}", int'({fail, fail_code}), int'(r));
                end
            end
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(busy == 1'b0 && done == 1'b0 && fb_req == 1'b0, "R11", "reset outputs busy/done/req",
            int'({busy, done, fb_req}), 0);
        chk(fail == 1'b0 && fail_code == 2'd0, "R11", "reset result", int'({fail, fail_code}), 0);

        // R1 R4 R5: program, one unsettled pair then settled
        ew(UA, 8'hAA, "R1"); ew(UB, 8'h55, "R1"); ew(UA, 8'hA0, "R1"); ew(19'h12345, 8'h5A, "R1");
        er(19'h12345, 8'h00, "R5"); er(19'h12345, 8'h40, "R5");
        er(19'h12345, 8'h00, "R4"); er(19'h12345, 8'h00, "R4");
        eres(1'b0, 2'd0, "R4");
        kick(2'd0, 19'h12345, 8'h5A, '0, 16'd100);
        finish_op("R1");

        // R2 R4: whole-array erase settled at once
        erase_head("R2"); ew(UA, 8'h10, "R2");
        er('0, 8'h40, "R4"); er('0, 8'h40, "R4");
        eres(1'b0, 2'd0, "R2");
        kick(2'd1, 19'h7ABCD, 8'h00, '0, 16'd100);
        finish_op("R2");

        // R6: overrun flagged and still toggling on the confirm pair
        ew(UA, 8'hAA, "R1"); ew(UB, 8'h55, "R1"); ew(UA, 8'hA0, "R1"); ew(19'h00777, 8'h3C, "R1");
        er(19'h00777, 8'h00, "R6"); er(19'h00777, 8'h60, "R6");
        er(19'h00777, 8'h20, "R6"); er(19'h00777, 8'h60, "R6");
        ew('0, 8'hF0, "R6");
        eres(1'b1, 2'd1, "R6");
        kick(2'd0, 19'h00777, 8'h3C, '0, 16'd100);
        finish_op("R6");

        // R6: overrun flagged but confirm pair settled
        erase_head("R2"); ew(UA, 8'h10, "R2");
        er('0, 8'h00, "R6"); er('0, 8'h60, "R6"); er('0, 8'h60, "R6"); er('0, 8'h60, "R6");
        eres(1'b0, 2'd0, "R6");
        kick(2'd1, '0, 8'h00, '0, 16'd100);
        finish_op("R6");

        // R8: poll limit of 3 unsettled pairs
        ew(UA, 8'hAA, "R1"); ew(UB, 8'h55, "R1"); ew(UA, 8'hA0, "R1"); ew(19'h40000, 8'h01, "R1");
        for (int i = 0; i < 3; i++) begin
            er(19'h40000, 8'h00, "R8"); er(19'h40000, 8'h40, "R8");
        end
        ew('0, 8'hF0, "R8");
        eres(1'b1, 2'd2, "R8");
        kick(2'd0, 19'h40000, 8'h01, '0, 16'd3);
        finish_op("R8");

        // R3: sectors 2 and 5, both accepted
        erase_head("R3"); ew(19'h20000, 8'h30, "R3");
        er(19'h20000, 8'h00, "R3"); ew(19'h50000, 8'h30, "R3"); er(19'h20000, 8'h40, "R3");
        er(19'h20000, 8'h00, "R4"); er(19'h20000, 8'h00, "R4");
        eres(1'b0, 2'd0, "R3");
        kick(2'd2, '0, 8'h00, 8'h24, 16'd100);
        finish_op("R3");

        // R7: sectors 1,3,6; window shut after adding sector 3
        erase_head("R3"); ew(19'h10000, 8'h30, "R3");
        er(19'h10000, 8'h00, "R3"); ew(19'h30000, 8'h30, "R3"); er(19'h10000, 8'h08, "R7");
        er(19'h10000, 8'h08, "R7"); er(19'h10000, 8'h08, "R7");
        ew('0, 8'hF0, "R7");
        eres(1'b1, 2'd3, "R7");
        kick(2'd2, '0, 8'h00, 8'h4A, 16'd100);
        finish_op("R7");

        // R7: sectors 0,7; window already shut before the added write
        erase_head("R3"); ew(19'h00000, 8'h30, "R3");
        er(19'h00000, 8'h08, "R7");
        er(19'h00000, 8'h48, "R7"); er(19'h00000, 8'h48, "R7");
        ew('0, 8'hF0, "R7");
        eres(1'b1, 2'd3, "R7");
        kick(2'd2, '0, 8'h00, 8'h81, 16'd100);
        finish_op("R7");

        // R9 R10: stalled handshake, second start while busy is ignored
        stall = 1'b1;
        ew(UA, 8'hAA, "R10"); ew(UB, 8'h55, "R10"); ew(UA, 8'hA0, "R10"); ew(19'h7FFFF, 8'hC3, "R10");
        er(19'h7FFFF, 8'h40, "R10"); er(19'h7FFFF, 8'h40, "R10");
        eres(1'b0, 2'd0, "R9");
        kick(2'd0, 19'h7FFFF, 8'hC3, '0, 16'd100);
        repeat (2) @(negedge clk);
        chk(busy == 1'b1, "R9", "busy during operation", int'(busy), 1);
        op = 2'd1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        finish_op("R9");
        stall = 1'b0;
        repeat (10) @(negedge clk);
        chk(exp_q.size() == 0 && busy == 1'b0, "R9", "ignored start left no work", int'(busy), 0);

        // R9: op 3 is not accepted
        kick(2'd3, 19'h00001, 8'h11, '0, 16'd100);
        repeat (5) @(negedge clk);
        chk(busy == 1'b0, "R9", "busy after op 3 start", int'(busy), 0);
        chk(fail == 1'b0 && fail_code == 2'd0, "R11", "result held from last op", int'({fail, fail_code}), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule